// File: doc/BRIEF.md
# Universal Four-Bit Counter and Shift Register

This block is a clocked four-bit register whose next value is picked each cycle by a three-bit operation code. The operations are: modulo-16 count up, modulo-16 count down, shift toward the low end, shift toward the high end, parallel preset, bitwise invert, synchronous clear and hold. An active-high master reset clears the register at once, without waiting for a clock edge, and overrides every other input.

Counting needs two active-low enables. One of them serves two purposes: it is the trickle enable when counting, and it is the serial input at the low end when shifting toward the high end. The terminal-count output also serves two purposes. When counting, it goes low at the end of the count range. When shifting, it repeats the top data bit. So a single wire from the terminal-count output of a lower stage to the shared input of the next stage up chains stages for both wide counting and wide shifting toward the high end. The data bits are also provided in inverted form.

Top module: `ucsr4`

## Requirements
- R1: While `mr` is 1, the register reads 0000 at once, without a clock edge, whatever the other inputs are. It stays 0000 across clock edges for as long as `mr` is held.
- R2: With `op` = 000, a rising edge copies `preset` into `q`, with `preset[0]` going to `q[0]`.
- R3: With `op` = 001, a rising edge inverts every bit of `q`.
- R4: With `op` = 101, a rising edge sets `q` to 0000.
- R5: With `op` = 111, `q` keeps its value across an edge.
- R6: With `op` = 110 and both `cnt_en_n` and `trk_ser_n` at 0, a rising edge adds one to `q`, and 1111 wraps to 0000.
- R7: With `op` = 100 and both enables at 0, a rising edge subtracts one from `q`, and 0000 wraps to 1111.
- R8: In either count code, if `cnt_en_n` or `trk_ser_n` is 1, `q` does not change.
- R9: With `op` = 010, a rising edge loads `q[3]` from `ser_hi` and loads each lower bit from the bit one place above it.
- R10: With `op` = 011, a rising edge loads `q[0]` from `trk_ser_n`, taken as plain data, and loads each higher bit from the bit one place below it.
- R11: With `op` = 110, `tc` is 0 exactly when `q` is 1111. With `op` = 100, `tc` is 0 exactly when `q` is 0000. In both cases `tc` is a direct decode of the current state and the code.
- R12: With `op` = 010 or 011, `tc` equals `q[3]` with no register in the path. With codes 000, 001, 101 and 111, `tc` is 1.
- R13: `q_n` is always the bitwise inverse of `q`.
- R14: When the `tc` of one stage drives `trk_ser_n` of a second stage, the pair counts up and down as one 8-bit modulo-256 counter and shifts toward the high end as one 8-bit shift register. Wiring the upper stage's `q[0]` to the lower stage's `ser_hi` gives an 8-bit shift toward the low end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mr | input | 1 | Asynchronous master clear, active high |
| op | input | 3 | Operation code |
| cnt_en_n | input | 1 | Parallel count enable, active low |
| trk_ser_n | input | 1 | Trickle count enable (active low) and low-end serial data |
| ser_hi | input | 1 | Serial data entering the top bit on a shift toward the low end |
| preset | input | 4 | Parallel preset word |
| q | output | 4 | Register contents |
| q_n | output | 4 | Inverted register contents |
| tc | output | 1 | Terminal count in count codes; top data bit in shift codes |

## Verification
On every cycle, the embedded properties check the effect of the load, invert, clear and hold codes. They also check that counting freezes when either enable is high, that the `tc` decode is right in every code group, and that `q_n` is the inverse of `q`. Several behaviours can only be shown by the bench's scenarios: the clear by master reset, which acts between clock edges; the wrap in both count directions; the serial entry at each end of the register; and the joint behaviour of two chained stages, which the bench checks against an 8-bit model over hundreds of steps.

// File: rtl/ucsr_pkg.sv
package ucsr_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'b000,
        OP_INV    = 3'b001,
        OP_SH_LO  = 3'b010,
        OP_SH_HI  = 3'b011,
        OP_DOWN   = 3'b100,
        OP_CLEAR  = 3'b101,
        OP_UP     = 3'b110,
        OP_HOLD   = 3'b111
    } op_e;
endpackage

// File: rtl/ucsr_next.sv
module ucsr_next
    import ucsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    input  logic             cnt_en_n,
    input  logic             trk_ser_n,
    input  logic             ser_hi,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic go;
    assign go = !cnt_en_n && !trk_ser_n;

    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = preset;
            OP_INV:   nxt = ~cur;
            OP_SH_LO: nxt = {ser_hi, cur[WIDTH-1:1]};
            OP_SH_HI: nxt = {cur[WIDTH-2:0], trk_ser_n};
            OP_DOWN:  nxt = go ? cur - STEP : cur;
            OP_CLEAR: nxt = '0;
            OP_UP:    nxt = go ? cur + STEP : cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/ucsr_tc.sv
module ucsr_tc
    import ucsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    output logic             tc
);
    logic full, empty;
    assign full  = &cur;
    assign empty = ~|cur;

    always_comb begin
        case (op)
            OP_UP:             tc = ~full;
            OP_DOWN:           tc = ~empty;
            OP_SH_LO, OP_SH_HI: tc = cur[WIDTH-1];
            default:           tc = 1'b1;
        endcase
    end
endmodule

// File: rtl/ucsr4.sv
module ucsr4
    import ucsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mr,
    input  logic [2:0]       op,
    input  logic             cnt_en_n,
    input  logic             trk_ser_n,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_n,
    output logic             tc
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
        logic             armed;
    } state_t;

    state_t st_d, st_q;
    op_e    op_sel;
    logic [WIDTH-1:0] nxt_bits;

    assign op_sel = op_e'(op);

    ucsr_next #(.WIDTH(WIDTH)) next_i (
        .op(op_sel), .cur(st_q.bits), .preset(preset),
        .cnt_en_n(cnt_en_n), .trk_ser_n(trk_ser_n), .ser_hi(ser_hi),
        .nxt(nxt_bits)
    );

    ucsr_tc #(.WIDTH(WIDTH)) tc_i (
        .op(op_sel), .cur(st_q.bits), .tc(tc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.bits  = nxt_bits;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or posedge mr) begin
        if (mr) st_q <= '0;
        else    st_q <= st_d;
    end

    assign q   = st_q.bits;
    assign q_n = ~st_q.bits;

    a_r2_load: assert property (@(posedge clk) disable iff (mr)
        (st_q.armed && $past(op) == 3'b000) |-> (q == $past(preset)));
    a_r3_invert: assert property (@(posedge clk) disable iff (mr)
        (st_q.armed && $past(op) == 3'b001) |-> (q == ~$past(q)));
    a_r4_clear: assert property (@(posedge clk) disable iff (mr)
        (st_q.armed && $past(op) == 3'b101) |-> (q == '0));
    a_r5_hold: assert property (@(posedge clk) disable iff (mr)
        (st_q.armed && $past(op) == 3'b111) |-> $stable(q));
    a_r8_count_gated: assert property (@(posedge clk) disable iff (mr)
        (st_q.armed && ($past(op) == 3'b110 || $past(op) == 3'b100)
         && ($past(cnt_en_n) || $past(trk_ser_n))) |-> $stable(q));
    a_r11_tc_up: assert property (@(posedge clk) disable iff (mr)
        (op == 3'b110) |-> (tc == (q != '1)));
    a_r11_tc_down: assert property (@(posedge clk) disable iff (mr)
        (op == 3'b100) |-> (tc == (q != '0)));
    a_r12_tc_shift: assert property (@(posedge clk) disable iff (mr)
        (op == 3'b010 || op == 3'b011) |-> (tc == q[WIDTH-1]));
    a_r12_tc_idle: assert property (@(posedge clk) disable iff (mr)
        (op == 3'b000 || op == 3'b001 || op == 3'b101 || op == 3'b111) |-> tc);
    a_r13_compl: assert property (@(posedge clk) disable iff (mr)
        (q_n ^ q) == '1);
endmodule

// File: tb/ucsr4_tb_top.sv
module ucsr4_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic       mr = 1'b1;
    logic [2:0] op = 3'b111;
    logic       cep = 1'b0, cet = 1'b0, d3 = 1'b0;
    logic [3:0] pre = 4'h0;
    logic [3:0] q, q_n;
    logic       tc;

    ucsr4 dut_i (.clk(clk), .mr(mr), .op(op), .cnt_en_n(cep), .trk_ser_n(cet),
                 .ser_hi(d3), .preset(pre), .q(q), .q_n(q_n), .tc(tc));

    logic       ch_mr = 1'b1;
    logic [2:0] ch_op = 3'b111;
    logic       ch_d0 = 1'b0, ch_d3 = 1'b0;
    logic [7:0] ch_pre = 8'h00;
    logic [3:0] lo_q, lo_qn, hi_q, hi_qn;
    logic       lo_tc, hi_tc;

    ucsr4 lo_i (.clk(clk), .mr(ch_mr), .op(ch_op), .cnt_en_n(1'b0), .trk_ser_n(ch_d0),
                .ser_hi(hi_q[0]), .preset(ch_pre[3:0]), .q(lo_q), .q_n(lo_qn), .tc(lo_tc));
    ucsr4 hi_i (.clk(clk), .mr(ch_mr), .op(ch_op), .cnt_en_n(1'b0), .trk_ser_n(lo_tc),
                .ser_hi(ch_d3), .preset(ch_pre[7:4]), .q(hi_q), .q_n(hi_qn), .tc(hi_tc));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // row: op, preset, cnt_en_n, trk_ser_n, ser_hi, expected q, expected tc
    localparam int NV = 18;
    localparam logic [14:0] VEC [NV] = '{
        {3'b000, 4'hA, 1'b0, 1'b0, 1'b0, 4'hA, 1'b1}, // R2 load
        {3'b001, 4'h0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b1}, // R3 invert
        {3'b110, 4'h0, 1'b0, 1'b0, 1'b0, 4'h6, 1'b1}, // R6 up
        {3'b110, 4'h0, 1'b1, 1'b0, 1'b0, 4'h6, 1'b1}, // R8 parallel enable off
        {3'b110, 4'h0, 1'b0, 1'b1, 1'b0, 4'h6, 1'b1}, // R8 trickle enable off
        {3'b000, 4'hE, 1'b0, 1'b0, 1'b0, 4'hE, 1'b1}, // R2
        {3'b110, 4'h0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0}, // R6 R11 full
        {3'b110, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1}, // R6 wrap
        {3'b100, 4'h0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1}, // R7 wrap
        {3'b100, 4'h0, 1'b1, 1'b0, 1'b0, 4'hF, 1'b1}, // R8 down gated
        {3'b000, 4'h1, 1'b0, 1'b0, 1'b0, 4'h1, 1'b1}, // R2
        {3'b100, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0}, // R7 R11 empty
        {3'b010, 4'h0, 1'b0, 1'b0, 1'b1, 4'h8, 1'b1}, // R9 R12
        {3'b010, 4'h0, 1'b0, 1'b0, 1'b0, 4'h4, 1'b0}, // R9 R12
        {3'b011, 4'h0, 1'b0, 1'b1, 1'b0, 4'h9, 1'b1}, // R10 R12
        {3'b011, 4'h0, 1'b0, 1'b0, 1'b0, 4'h2, 1'b0}, // R10 R12
        {3'b111, 4'hF, 1'b0, 1'b0, 1'b1, 4'h2, 1'b1}, // R5 R12
        {3'b101, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1}  // R4
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] m;
        logic [7:0] lfsr;
        #35;
        chk("R1 reset q", {4'h0, q}, 8'h00);
        chk("R13 reset q_n", {4'h0, q_n}, 8'h0F);
        chk("R12 reset tc hold", {7'h0, tc}, 8'h01);
        mr = 1'b0;
        #10;
        for (int i = 0; i < NV; i++) begin
            {op, pre, cep, cet, d3} = VEC[i][14:5];
            @(posedge clk); #5;
            chk($sformatf("R2-R12 vector %0d q", i), {4'h0, q}, {4'h0, VEC[i][4:1]});
            chk($sformatf("R11/R12 vector %0d tc", i), {7'h0, tc}, {7'h0, VEC[i][0]});
            chk("R13 q_n", {4'h0, q_n}, {4'h0, ~VEC[i][4:1]});
        end
        // R12: tc follows q3 combinationally when the code changes
        op = 3'b000; pre = 4'h9; @(posedge clk); #5;
        op = 3'b010; #1;
        chk("R12 tc=q3 in shift, no clock", {7'h0, tc}, 8'h01);
        op = 3'b110; #1;
        chk("R11 tc up not full", {7'h0, tc}, 8'h01);
        pre = 4'h0; op = 3'b000; @(posedge clk); #5;
        op = 3'b100; #1;
        chk("R11 tc down at zero, no clock", {7'h0, tc}, 8'h00);
        // R1: asynchronous clear between edges, overriding load
        op = 3'b000; pre = 4'hF; @(posedge clk); #5;
        chk("R2 load F", {4'h0, q}, 8'h0F);
        mr = 1'b1; #1;
        chk("R1 async clear", {4'h0, q}, 8'h00);
        @(posedge clk); #5;
        chk("R1 held over load", {4'h0, q}, 8'h00);
        mr = 1'b0;

        // R14 chained stages
        #3; ch_mr = 1'b0;
        ch_op = 3'b000; ch_pre = 8'hF0; @(posedge clk); #5;
        m = 8'hF0;
        chk("R14 chain load", {hi_q, lo_q}, m);
        ch_op = 3'b110; ch_d0 = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #5;
            m = m + 8'd1;
            chk("R14 chain up", {hi_q, lo_q}, m);
        end
        ch_op = 3'b000; ch_pre = 8'h03; @(posedge clk); #5;
        m = 8'h03;
        ch_op = 3'b100;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #5;
            m = m - 8'd1;
            chk("R14 chain down", {hi_q, lo_q}, m);
        end
        ch_op = 3'b011; lfsr = 8'hB5;
        for (int i = 0; i < 24; i++) begin
            ch_d0 = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2], lfsr[7:1]};
            @(posedge clk); #5;
            m = {m[6:0], ch_d0};
            chk("R14 chain shift up", {hi_q, lo_q}, m);
        end
        ch_op = 3'b010;
        for (int i = 0; i < 24; i++) begin
            ch_d3 = lfsr[1];
            lfsr = {lfsr[0] ^ lfsr[3], lfsr[7:1]};
            @(posedge clk); #5;
            m = {ch_d3, m[7:1]};
            chk("R14 chain shift down", {hi_q, lo_q}, m);
        end
        finish_run();
    end
endmodule